// File: doc/BRIEF.md
# Device Interrupt Steering Controller

This block sits between a set of device interrupt lines and the processors of a chip. It holds one routing entry and one control entry for each device source. The routing entry names a target CPU and an interrupt vector. The control entry holds a mask flag and a pending flag. An unmasked source that raises its line is accepted. Acceptance sets its pending flag and masks the source in hardware. The block then issues a one-cycle post that carries the routed CPU id and vector.

Software reaches both tables through a small register port. The port uses 8-byte slots, and a slot's index is the byte offset shifted right by three. Slots 0 to NUM_SRC-1 are the routing entries. Slots NUM_SRC to 2*NUM_SRC-1 are the control entries. An offset above these slots is unmapped. Once a source has been serviced, software writes its control entry to clear the pending flag and to unmask the source again.

When several sources are accepted at once, the block posts them one per cycle, lowest source id first. Each source waits until its own post has gone out.

Top module: `irq_steer`

## Requirements
- R1: After reset every source is masked, no source is pending, every routing CPU and vector field reads zero, and no post or error is issued.
- R2: A routing write loads the CPU id from data bits 12:8 and the vector from bits 5:0. A routing read returns the CPU id in bits 12:8, the vector in bits 5:0, and zero in all other bits.
- R3: A control read returns the mask in bit 2 and the pending flag in bit 0, with zero in all other bits.
- R4: A control write loads the mask from bit 2. A 1 in bit 1 clears the pending flag, and a 0 in bit 1 leaves it unchanged.
- R5: A device line that is raised while its source is masked has no effect: no pending change, no mask change and no post.
- R6: An accepted device line sets both mask and pending. The post (post_valid, post_cpu, post_vec) carries the routing entry as held at that time and appears in the cycle after the line was sampled, unless a lower source is waiting. Acceptance takes precedence over a control write to the same source in the same cycle.
- R7: The slot index is reg_addr shifted right by 3, so address bits 2:0 do not select a register. Routing entries occupy slots 0 to NUM_SRC-1, and control entries occupy slots NUM_SRC to 2*NUM_SRC-1.
- R8: Sources accepted together are posted one per cycle in ascending source id, and a waiting source stays queued until it is posted.
- R9: An access to an unmapped slot reads zero, changes no register, and raises reg_err for one cycle. A mapped access does not raise reg_err.
- R10: Each accepted arrival produces exactly one post. post_valid is low in every cycle with nothing to post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | NUM_SRC | Device interrupt lines, one per source, sampled each cycle |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset within the register window |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered, valid the cycle after a read |
| reg_err | output | 1 | One-cycle flag after an unmapped access |
| post_valid | output | 1 | One-cycle interrupt post strobe |
| post_cpu | output | CPU_W | Target CPU of the post |
| post_vec | output | VEC_W | Vector of the post |

## Verification
The assertions check on every cycle that acceptance leaves a source both masked and pending, and that a masked arrival changes nothing. They also check that a waiting source stays queued, that at most one source is granted per cycle, that routing writes land in the addressed entry, and that the error flag appears only after an access. The ascending posting order, the exact bit layout of register reads, the pending-clear-without-unmask case and the ignored unmapped writes can only be shown by the bench. The bench does this by comparing every post and every read against its own model, under directed bursts and random traffic.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  // register slot decode result
  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_ROUTE = 2'd1,
    SEL_CTL   = 2'd2
  } reg_sel_e;

  // field positions that software depends on
  localparam int ROUTE_CPU_LSB = 8;
  localparam int ROUTE_VEC_LSB = 0;
  localparam int CTL_MASK_BIT  = 2;
  localparam int CTL_CLR_BIT   = 1;
  localparam int CTL_PEND_BIT  = 0;

endpackage

// File: rtl/irq_steer_route.sv
module irq_steer_route #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SRC_W-1:0] wr_idx,
  input  logic [CPU_W-1:0] wr_cpu,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic [SRC_W-1:0] rd_idx,
  output logic [CPU_W-1:0] rd_cpu,
  output logic [VEC_W-1:0] rd_vec,
  input  logic [SRC_W-1:0] pk_idx,
  output logic [CPU_W-1:0] pk_cpu,
  output logic [VEC_W-1:0] pk_vec
);

  logic [CPU_W-1:0] cpu_mem [NUM_SRC];
  logic [VEC_W-1:0] vec_mem [NUM_SRC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        cpu_mem[i] <= '0;
        vec_mem[i] <= '0;
      end
    end else if (wr_en) begin
      cpu_mem[wr_idx] <= wr_cpu;
      vec_mem[wr_idx] <= wr_vec;
    end
  end

  // one read port for software, one for the post path
  assign rd_cpu = cpu_mem[rd_idx];
  assign rd_vec = vec_mem[rd_idx];
  assign pk_cpu = cpu_mem[pk_idx];
  assign pk_vec = vec_mem[pk_idx];

  // R2
  route_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cpu_mem[$past(wr_idx)] == $past(wr_cpu)) &&
              (vec_mem[$past(wr_idx)] == $past(wr_vec)));

endmodule

// File: rtl/irq_steer_ctl.sv
module irq_steer_ctl #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq,
  input  logic               wr_en,
  input  logic [SRC_W-1:0]   wr_idx,
  input  logic               wr_mask,
  input  logic               wr_clr,
  input  logic [NUM_SRC-1:0] grant,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] cand_o
);

  logic [NUM_SRC-1:0] mask_q, pend_q, wait_q, accept, wr_hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign wr_hit[i] = wr_en && (wr_idx == SRC_W'(i));
    assign accept[i] = irq[i] && !mask_q[i];
    assign cand_o[i] = wait_q[i] || accept[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[i] <= 1'b1;
        pend_q[i] <= 1'b0;
        wait_q[i] <= 1'b0;
      end else begin
        if (accept[i]) begin
          mask_q[i] <= 1'b1;
          pend_q[i] <= 1'b1;
        end else if (wr_hit[i]) begin
          mask_q[i] <= wr_mask;
          if (wr_clr) pend_q[i] <= 1'b0;
        end
        wait_q[i] <= cand_o[i] && !grant[i];
      end
    end

    // R6
    accept_sets_both_chk: assert property (@(posedge clk) disable iff (rst)
      (irq[i] && !mask_q[i]) |=> (mask_q[i] && pend_q[i]));

    // R5
    masked_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (irq[i] && mask_q[i] && !wr_hit[i] && !wait_q[i]) |=>
        ($stable(pend_q[i]) && mask_q[i] && !wait_q[i]));

    // R8
    wait_held_chk: assert property (@(posedge clk) disable iff (rst)
      (wait_q[i] && !grant[i]) |=> wait_q[i]);
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/irq_steer_pick.sv
module irq_steer_pick #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [NUM_SRC-1:0] gnt
);

  // lowest index wins: scan downward, last hit overrides
  always_comb begin
    gnt = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_steer.sv
module irq_steer
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] dev_irq,
  input  logic               reg_en,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_err,
  output logic               post_valid,
  output logic [CPU_W-1:0]   post_cpu,
  output logic [VEC_W-1:0]   post_vec
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int IDX_W = ADDR_W - 3;

  // slot decode
  logic [IDX_W-1:0] slot, ctl_off;
  logic             route_hit, ctl_hit;
  logic [SRC_W-1:0] src_idx;
  reg_sel_e         sel;

  assign slot      = reg_addr[ADDR_W-1:3];
  assign ctl_off   = slot - IDX_W'(NUM_SRC);
  assign route_hit = slot < IDX_W'(NUM_SRC);
  assign ctl_hit   = !route_hit && (slot < IDX_W'(2 * NUM_SRC));
  assign src_idx   = route_hit ? slot[SRC_W-1:0] : ctl_off[SRC_W-1:0];
  assign sel       = route_hit ? SEL_ROUTE : (ctl_hit ? SEL_CTL : SEL_NONE);

  logic unused_bits;
  assign unused_bits = ^{reg_addr[2:0], slot, ctl_off};

  // storage
  logic [CPU_W-1:0]   rd_cpu, pk_cpu;
  logic [VEC_W-1:0]   rd_vec, pk_vec;
  logic [SRC_W-1:0]   pk_idx;
  logic [NUM_SRC-1:0] mask_v, pend_v, cand_v, gnt;

  irq_steer_route #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CPU_W(CPU_W), .VEC_W(VEC_W)
  ) u_route (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_en && reg_we && (sel == SEL_ROUTE)),
    .wr_idx (src_idx),
    .wr_cpu (reg_wdata[ROUTE_CPU_LSB +: CPU_W]),
    .wr_vec (reg_wdata[ROUTE_VEC_LSB +: VEC_W]),
    .rd_idx (src_idx),
    .rd_cpu (rd_cpu),
    .rd_vec (rd_vec),
    .pk_idx (pk_idx),
    .pk_cpu (pk_cpu),
    .pk_vec (pk_vec)
  );

  irq_steer_ctl #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .irq     (dev_irq),
    .wr_en   (reg_en && reg_we && (sel == SEL_CTL)),
    .wr_idx  (src_idx),
    .wr_mask (reg_wdata[CTL_MASK_BIT]),
    .wr_clr  (reg_wdata[CTL_CLR_BIT]),
    .grant   (gnt),
    .mask_o  (mask_v),
    .pend_o  (pend_v),
    .cand_o  (cand_v)
  );

  irq_steer_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req (cand_v),
    .gnt (gnt)
  );

  always_comb begin
    pk_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (gnt[i]) pk_idx = SRC_W'(i);
    end
  end

  // read mux
  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    unique case (sel)
      SEL_ROUTE: begin
        rd_next[ROUTE_CPU_LSB +: CPU_W] = rd_cpu;
        rd_next[ROUTE_VEC_LSB +: VEC_W] = rd_vec;
      end
      SEL_CTL: begin
        rd_next[CTL_MASK_BIT] = mask_v[src_idx];
        rd_next[CTL_PEND_BIT] = pend_v[src_idx];
      end
      default: ;
    endcase
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_err    <= 1'b0;
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else begin
      reg_err    <= reg_en && (sel == SEL_NONE);
      if (reg_en && !reg_we) reg_rdata <= rd_next;
      post_valid <= |gnt;
      if (|gnt) begin
        post_cpu <= pk_cpu;
        post_vec <= pk_vec;
      end
    end
  end

  // R9
  err_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_en) |-> !reg_err);

  // R10
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt == '0) || (cand_v != '0)));

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!post_valid && !reg_err));

endmodule

// File: tb/irq_steer_bench.sv
module irq_steer_bench;

  localparam int N      = 8;
  localparam int CLK_NS = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  dev_irq = '0;
  logic          reg_en = 1'b0, reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_err, post_valid;
  logic [4:0]    post_cpu;
  logic [5:0]    post_vec;

  always #(CLK_NS / 2) clk = ~clk;

  irq_steer u_irq_steer (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .post_valid(post_valid), .post_cpu(post_cpu),
    .post_vec(post_vec)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of the register state
  logic [4:0]   m_cpu [N];
  logic [5:0]   m_vec [N];
  logic [N-1:0] m_mask, m_pend, m_wait;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_read(logic [7:0] a);
    int s = int'(a >> 3);
    if (s < N) return {19'd0, m_cpu[s], 2'd0, m_vec[s]};
    if (s < 2 * N) return {29'd0, m_mask[s - N], 1'b0, m_pend[s - N]};
    return 32'd0;
  endfunction

  function automatic bit mdl_unmapped(logic [7:0] a);
    return int'(a >> 3) >= 2 * N;
  endfunction

  // one clock: drive, let the edge pass, check at the falling edge
  task automatic step(logic [N-1:0] irq, bit en, bit we, logic [7:0] a,
                      logic [31:0] wd, string tag);
    logic [31:0]  exp_rd;
    bit           exp_err, exp_pv;
    logic [N-1:0] acc, cand;
    int           g, s;
    string        t;
    dev_irq = irq; reg_en = en; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    exp_rd  = mdl_read(a);
    exp_err = en && mdl_unmapped(a);
    acc  = irq & ~m_mask;
    cand = m_wait | acc;
    g = -1;
    for (int i = N - 1; i >= 0; i--) if (cand[i]) g = i;
    exp_pv = (g >= 0);
    t = (tag != "") ? tag : (($countones(cand) > 1) ? "R8" :
        ((irq & m_mask) != 0 ? "R5" : "R6"));
    chk(t, {31'd0, post_valid}, {31'd0, exp_pv});
    if (exp_pv) begin
      chk(t, {27'd0, post_cpu}, {27'd0, m_cpu[g]});
      chk(t, {26'd0, post_vec}, {26'd0, m_vec[g]});
    end
    chk((tag != "") ? tag : "R9", {31'd0, reg_err}, {31'd0, exp_err});
    if (en && !we)
      chk((tag != "") ? tag : (int'(a >> 3) < N ? "R2" : "R3"), reg_rdata, exp_rd);
    // model update: software write, then acceptance wins
    s = int'(a >> 3);
    if (en && we && s < N) begin
      m_cpu[s] = wd[12:8];
      m_vec[s] = wd[5:0];
    end else if (en && we && s < 2 * N) begin
      m_mask[s - N] = wd[2];
      if (wd[1]) m_pend[s - N] = 1'b0;
    end
    m_mask = m_mask | acc;
    m_pend = m_pend | acc;
    m_wait = cand;
    if (g >= 0) m_wait[g] = 1'b0;
    dev_irq = '0; reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(int slot, string tag);
    step('0, 1, 0, 8'(slot * 8), 32'd0, tag);
  endtask

  task automatic wr(int slot, logic [31:0] d, string tag);
    step('0, 1, 1, 8'(slot * 8), d, tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_cpu[i] = '0;
      m_vec[i] = '0;
    end
    m_mask = '1; m_pend = '0; m_wait = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every slot
    for (int i = 0; i < 2 * N; i++) rd(i, "R1");

    // R2: full-width write keeps only the fields
    wr(3, 32'hFFFF_FFFF, "R2");
    rd(3, "R2");
    chk("R2", reg_rdata, 32'h0000_1F3F);
    // R7: low address bits do not select
    step('0, 1, 1, 8'(5 * 8 + 3), 32'h0000_0A15, "R7");
    step('0, 1, 0, 8'(5 * 8 + 6), 32'd0, "R7");
    chk("R7", reg_rdata, 32'h0000_0A15);

    // R4: unmask source 3, R6: accept it
    wr(N + 3, 32'h0, "R4");
    step(8'h08, 0, 0, 8'd0, 32'd0, "R6");
    rd(N + 3, "R3");
    chk("R3", reg_rdata, 32'h5);
    // R5: masked arrival dropped
    step(8'h08, 0, 0, 8'd0, 32'd0, "R5");
    step('0, 0, 0, 8'd0, 32'd0, "R10");
    // R4: mask kept with clear bit 0 leaves pending
    wr(N + 3, 32'h4, "R4");
    rd(N + 3, "R4");
    chk("R4", reg_rdata, 32'h5);
    wr(N + 3, 32'h2, "R4");
    rd(N + 3, "R4");
    chk("R4", reg_rdata, 32'h0);

    // R8: all sources at once
    for (int i = 0; i < N; i++) wr(i, {19'd0, 5'(i + 1), 2'd0, 6'(i * 3)}, "R2");
    for (int i = 0; i < N; i++) wr(N + i, 32'h2, "R4");
    step('1, 0, 0, 8'd0, 32'd0, "R8");
    for (int i = 0; i < N + 2; i++) step(8'h01, 0, 0, 8'd0, 32'd0, "R8");

    // R9: unmapped read and write
    step('0, 1, 0, 8'(2 * N * 8), 32'd0, "R9");
    chk("R9", reg_rdata, 32'd0);
    step('0, 1, 1, 8'(2 * N * 8 + 8), 32'hFFFF_FFFF, "R9");
    for (int i = 0; i < 2 * N; i++) rd(i, "R9");

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] irq = ($urandom % 4 == 0) ? N'($urandom) : '0;
      bit en = ($urandom % 3) != 0;
      bit we = ($urandom % 2) != 0;
      logic [7:0] a = 8'($urandom % ((2 * N + 2) * 8));
      logic [31:0] d = $urandom;
      step(irq, en, we, a, d, "");
    end
    for (int i = 0; i < N + 2; i++) step('0, 0, 0, 8'd0, 32'd0, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule